// File: doc/BRIEF.md
# Multichannel ADC Lane Pattern Formatter and Serializer

This block takes one 12-bit sample per channel at every word boundary and picks the word each serial lane sends in place of it. The word is the sample itself, coded as offset binary or two's complement, or a built-in test word: a fixed half-ones, half-zeros sync word or a ramp that counts up once per word. Test words are the same on every lane and ignore both the sample and the coding choice. They let a receiver find word alignment without any analog input.

Each word is shifted out most significant bit first, one bit per clock, with a word length of 12 or 14 bits. A word-boundary strobe runs alongside the lanes. When a normal sample is sent as a 14-bit word, two zero bits follow its least significant bit. A test word is widened instead, by repeating its first and last bits. Mode, coding, length and samples are all captured at the first bit of a word, so one word never mixes two settings.

Top module: `adc_lane_formatter`

## Requirements
- R1: While rst_n is low, every lane output and frame_out are 0. The first word is loaded on the first rising clock edge after rst_n goes high, and its first bit appears after that edge.
- R2: pat_sel encoding: 2'b00 sends samples, 2'b01 sends the sync word, 2'b10 sends the ramp, and 2'b11 behaves like 2'b00.
- R3: In sample mode with twos_en=0 and long_word=0, each lane sends its 12-bit sample unchanged, MSB first, in 12 clocks.
- R4: In sample mode with twos_en=1, the word sent is the sample with its MSB (bit 11) inverted.
- R5: In sample mode with long_word=1, each lane sends its coded 12-bit sample followed by two 0 bits, in 14 clocks.
- R6: The sync word is 111111000000 in 12-bit words and 11111110000000 in 14-bit words.
- R7: The ramp value is 0 in the first word after entering ramp mode. It rises by 1 in each later ramp word and wraps from 4095 to 0. A 14-bit ramp word is {r[11], r, r[0]}.
- R8: In a test mode, every lane sends the identical word, whatever the samples and twos_en are.
- R9: frame_out is 1 for the first half of each word (6 of 12 bits, 7 of 14 bits) and 0 for the rest.
- R10: pat_sel, twos_en, long_word and the samples are used only at the first bit of a word. Changing them during a word has no effect on that word.
- R11: After a test mode, the first word sent in sample mode already carries the selected coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per lane per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_bus | input | NCH*12 | Channel c sample in bits [c*12+11 : c*12] |
| pat_sel | input | 2 | Word source: 00 sample, 01 sync, 10 ramp, 11 sample |
| twos_en | input | 1 | 1 selects two's-complement coding of samples |
| long_word | input | 1 | 1 selects 14-bit words, 0 selects 12-bit words |
| ser_out | output | NCH | Serial bit of each lane, MSB first |
| frame_out | output | 1 | High during the first half of each word |

## Verification
Sample mode is swept across the whole 12-bit range in fixed steps, giving each lane a different offset. This is repeated for every combination of coding and word length, so a bit-order error, a lost pad bit or a wrong coding bit shows up on some lane. The sync and ramp words are sent with non-zero samples and two's complement turned on, which shows that test words ignore both. More than 4096 ramp words are sent, with the word length changing along the way, to cover wrap-around and widening. Mid-word changes to every input, and a return from a test mode to sample mode, separate capture at the word boundary from capture at any other time.

// File: rtl/adc_lane_formatter.sv
module adc_lane_formatter #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH*12-1:0] sample_bus,
  input  logic [1:0]       pat_sel,
  input  logic             twos_en,
  input  logic             long_word,
  output logic [NCH-1:0]   ser_out,
  output logic             frame_out
);
  localparam int DW = 12;
  localparam int WW = DW + 2;
  localparam logic [1:0] M_SYNC = 2'b01;
  localparam logic [1:0] M_RAMP = 2'b10;
  localparam logic [DW-1:0] SYNC_W = {{DW/2{1'b1}}, {DW/2{1'b0}}};

  logic [3:0]    bitpos;
  logic          started;
  logic [1:0]    mode_q;
  logic          len_q;
  logic [DW-1:0] ramp_q;

  wire [3:0] last = len_q ? 4'd13 : 4'd11;
  wire load = !started || (bitpos == last);
  wire test = (pat_sel == M_SYNC) || (pat_sel == M_RAMP);
  wire [DW-1:0] ramp_val = (mode_q == M_RAMP) ? ramp_q + 1'b1 : '0;
  wire [DW-1:0] pat = (pat_sel == M_SYNC) ? SYNC_W : ramp_val;
  wire [WW-1:0] pat_w = long_word ? {pat[DW-1], pat, pat[0]} : {pat, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      bitpos  <= '0;
      mode_q  <= '0;
      len_q   <= 1'b0;
      ramp_q  <= '0;
    end else if (load) begin
      started <= 1'b1;
      bitpos  <= '0;
      mode_q  <= pat_sel;
      len_q   <= long_word;
      if (pat_sel == M_RAMP) ramp_q <= ramp_val;
    end else begin
      bitpos <= bitpos + 4'd1;
    end
  end

  assign frame_out = started && (bitpos < (len_q ? 4'd7 : 4'd6));

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [WW-1:0] sh;
    wire [DW-1:0] smp = sample_bus[c*DW +: DW];
    wire [DW-1:0] cod = smp ^ {twos_en, {DW-1{1'b0}}};
    wire [WW-1:0] word = test ? pat_w : {cod, 2'b00};
    always_ff @(posedge clk) begin
      if (!rst_n)    sh <= '0;
      else if (load) sh <= word;
      else           sh <= {sh[WW-2:0], 1'b0};
    end
    assign ser_out[c] = sh[WW-1];
  end

  // R8
  lanes_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && (mode_q == M_SYNC || mode_q == M_RAMP)) |-> (ser_out == {NCH{ser_out[0]}}));

  // R6
  sync_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode_q == M_SYNC) |-> (ser_out[0] == frame_out));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !load) |=> ($stable(mode_q) && $stable(len_q)));

  // R9
  bitpos_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (bitpos <= last));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n |-> (ser_out == '0 && !frame_out)));
endmodule

// File: tb/adc_lane_formatter_tb_top.sv
module adc_lane_formatter_tb_top;
  localparam int NCH = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*12-1:0] sample_bus = '0;
  logic [1:0] pat_sel = 2'b00;
  logic twos_en = 1'b0;
  logic long_word = 1'b0;
  logic [NCH-1:0] ser_out;
  logic frame_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit prev_ramp = 0;
  logic [11:0] rv = '0;

  always #10 clk = ~clk;

  adc_lane_formatter #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_bus(sample_bus), .pat_sel(pat_sel),
    .twos_en(twos_en), .long_word(long_word), .ser_out(ser_out), .frame_out(frame_out));

  function automatic logic [13:0] expw(logic [1:0] m, logic f, logic l, logic [11:0] s, logic [11:0] r);
    logic [11:0] p;
    if (m == 2'b01 || m == 2'b10) begin
      p = (m == 2'b01) ? 12'hFC0 : r;
      return l ? {p[11], p, p[0]} : {p, 2'b00};
    end
    p = s ^ (f ? 12'h800 : 12'h000);
    return {p, 2'b00};
  endfunction

  task automatic check(bit ok, string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_word(logic [1:0] m, logic f, logic l, logic [11:0] base,
                          logic [11:0] step, bit midchg, string req);
    logic [13:0] got [NCH];
    logic [13:0] fr = '0;
    logic [11:0] smp [NCH];
    int len = l ? 14 : 12;
    for (int c = 0; c < NCH; c++) begin
      smp[c] = base + 12'(c) * step;
      sample_bus[c*12 +: 12] = smp[c];
      got[c] = '0;
    end
    pat_sel = m; twos_en = f; long_word = l;
    if (m == 2'b10) rv = prev_ramp ? rv + 12'd1 : 12'd0;
    prev_ramp = (m == 2'b10);
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) got[c] = {got[c][12:0], ser_out[c]};
      fr = {fr[12:0], frame_out};
      if (midchg && i == 0) begin
        pat_sel = m + 2'd1; twos_en = ~f; long_word = ~l;
        sample_bus = ~sample_bus;
      end
    end
    if (!l) begin
      for (int c = 0; c < NCH; c++) got[c] = got[c] << 2;
      fr = fr << 2;
    end
    for (int c = 0; c < NCH; c++)
      check(got[c] == expw(m, f, l, smp[c], rv), req, got[c], expw(m, f, l, smp[c], rv));
    check(fr == (l ? 14'b11111110000000 : 14'b11111100000000), "R9 frame strobe",
          fr, l ? 14'b11111110000000 : 14'b11111100000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ser_out == '0 && frame_out == 1'b0, "R1 reset", {5'd0, frame_out, ser_out}, '0);
    rst_n = 1'b1;
    // R1 first word right after release, R3 plain samples
    run_word(2'b00, 0, 0, 12'h000, 12'h1FF, 0, "R1 R3 first word");
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 2; l++) begin
        for (int v = 0; v < 4096; v += 53)
          run_word(2'b00, f[0], l[0], 12'(v), 12'h155, 0, f ? "R4 twos sweep" : (l ? "R5 long sweep" : "R3 sweep"));
        run_word(2'b00, f[0], l[0], 12'hFFF, 12'h000, 0, "R4 R5 all ones");
        run_word(2'b00, f[0], l[0], 12'h7FF, 12'h001, 0, "R4 R5 mid scale");
      end
    // R2 code 11 acts as sample mode
    run_word(2'b11, 1, 0, 12'h123, 12'h111, 0, "R2 reserved mode");
    run_word(2'b11, 0, 1, 12'h800, 12'h010, 0, "R2 reserved mode long");
    // R6 R8 sync ignores samples and coding
    run_word(2'b01, 0, 0, 12'h000, 12'h000, 0, "R6 sync 12");
    run_word(2'b01, 1, 1, 12'hABC, 12'h321, 0, "R6 R8 sync 14 twos");
    run_word(2'b01, 1, 0, 12'h5A5, 12'h0F0, 0, "R8 sync ignores inputs");
    // R11 back to samples with two's complement
    run_word(2'b00, 1, 0, 12'h0F0, 12'h101, 0, "R11 return to samples");
    // R7 ramp with wrap and length changes
    for (int i = 0; i < 4100; i++)
      run_word(2'b10, 1'(i % 2), 1'(i % 3 == 0), 12'(i), 12'h0AB, 0, "R7 R8 ramp");
    run_word(2'b01, 0, 1, 12'h000, 12'h000, 0, "R6 sync interlude");
    for (int i = 0; i < 3; i++)
      run_word(2'b10, 0, 0, 12'h777, 12'h001, 0, "R7 ramp restart");
    run_word(2'b00, 1, 1, 12'h0C3, 12'h044, 0, "R11 ramp to samples");
    // R10 mid-word changes ignored
    run_word(2'b00, 0, 0, 12'h3A5, 12'h111, 1, "R10 mid change sample");
    run_word(2'b00, 1, 1, 12'hC5A, 12'h0F1, 1, "R10 mid change long");
    run_word(2'b01, 0, 0, 12'h000, 12'h000, 1, "R10 mid change sync");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule